// File: doc/BRIEF.md
# Update-Qualified Wide Word Clock-Domain Crossing

This block carries a wide data word from a source clock domain into a destination clock domain that has no phase or frequency relation to it. Only one qualifier bit, the update signal, goes through a synchronizer. The word itself travels over plain wires. It is held steady in a source-side launch register long enough that the destination can sample it directly once the qualifier has arrived.

A source-side user raises `src_send` for one cycle with the word on `src_word`. The block accepts the request only when it is idle. It launches the word and changes the update level in the same source cycle, then reports busy for a parameterised number of source cycles. On the destination side, three flops carry the update level. An edge detector compares the last stage with one further delayed copy and produces a single load pulse. That pulse copies the launch register into the destination output register, and `dst_valid` is raised for one cycle.

Two event encodings can be selected. In the rising-edge encoding, the update level goes high for a fixed number of source cycles and then returns low. In the toggle encoding, every transfer inverts the level. The design relies on transfers being spaced at least 30 cycles of the slower clock apart. The minimum spacing parameter must be set to cover that, and no acknowledge returns to the source.

Top module: `qual_bus_xfer`

## Requirements
- R1: After either reset, `dst_word` is all zeros, `dst_valid` is 0, `src_busy` is 0 and `src_err` is 0.
- R2: For a send that is accepted (`src_send` high while `src_busy` low), `dst_word` shows the word present on `src_word` in that source cycle, in the same destination cycle in which `dst_valid` is high.
- R3: Each accepted transfer raises `dst_valid` for exactly one destination cycle.
- R4: Outside a `dst_valid` cycle, `dst_word` keeps its last captured value.
- R5: From the source cycle after an accepted send, `src_busy` reads high for exactly MIN_GAP source cycles, then drops.
- R6: A send attempted while `src_busy` is high is ignored: it produces no `dst_valid` pulse and does not change the word delivered.
- R7: A send attempted while `src_busy` is high sets `src_err`, which stays high until the source reset.
- R8: `dst_valid` appears no sooner than 3 and no later than 7 destination cycles after the source cycle that follows an accepted send, because the qualifier passes three destination flops and one edge-detect flop.
- R9: With EVENT set to toggle, every accepted transfer is still delivered exactly once with the correct word, including transfers spaced at the minimum interval.
- R10: Changing `src_word` after an accepted send does not alter the word that is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source-domain clock |
| src_rst_n | input | 1 | Source-domain active-low synchronous reset |
| src_send | input | 1 | Request to launch `src_word` |
| src_word | input | DATA_W | Word to transfer |
| src_busy | output | 1 | High while the spacing interval runs; sends are refused |
| src_err | output | 1 | Sticky flag: a send was refused |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst_n | input | 1 | Destination-domain active-low synchronous reset |
| dst_word | output | DATA_W | Last captured word |
| dst_valid | output | 1 | One-cycle pulse when `dst_word` has just been loaded |

## Verification
The bench drives a rising-edge instance and a toggle instance with the same stimulus. It sends words with all bits set and all bits clear, back to back at the minimum spacing. A rising-edge design that never returned the update level low would lose the second of these words, and a toggle design that detected only rises would lose every other word. The bench changes `src_word` right after each launch, which exposes any path that samples the live input instead of the launch register. It also sends a request in the middle of a busy window: a design that accepted it would emit an extra valid pulse or a different word, and a design with a non-sticky error flag would clear `src_err` early. It measures the busy length and the valid latency against their exact bounds.

// File: rtl/qbx_pkg.sv
`timescale 1ns/1ps
package qbx_pkg;
    // How the update qualifier encodes a new word
    typedef enum logic {
        QBX_EV_RISE   = 1'b0,   // level pulses high, a rising edge marks a word
        QBX_EV_TOGGLE = 1'b1    // level inverts, any change marks a word
    } qbx_event_e;
endpackage

// File: rtl/qbx_src.sv
`timescale 1ns/1ps
module qbx_src
    import qbx_pkg::*;
#(
    parameter int         DATA_W   = 64,
    parameter int         HOLD_CYC = 8,
    parameter int         MIN_GAP  = 48,
    parameter qbx_event_e EVENT    = QBX_EV_RISE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] launch_word,
    output logic              upd_lvl,
    output logic              busy,
    output logic              err
);
    localparam int GAP_W  = $clog2(MIN_GAP + 1);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              upd;
        logic [GAP_W-1:0]  gap;
        logic [HOLD_W-1:0] hold;
        logic              err;
    } src_state_t;

    src_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
        end
        if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
            if (st_q.hold == HOLD_W'(1)) begin
                st_d.upd = 1'b0;
            end
        end
        if (send) begin
            if (st_q.gap != '0) begin
                st_d.err = 1'b1;
            end else begin
                st_d.word = word;
                st_d.gap  = GAP_W'(MIN_GAP);
                if (EVENT == QBX_EV_RISE) begin
                    st_d.upd  = 1'b1;
                    st_d.hold = HOLD_W'(HOLD_CYC);
                end else begin
                    st_d.upd  = ~st_q.upd;
                    st_d.hold = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign launch_word = st_q.word;
    assign upd_lvl     = st_q.upd;
    assign busy        = (st_q.gap != '0);
    assign err         = st_q.err;
endmodule

// File: rtl/qbx_sync.sv
`timescale 1ns/1ps
module qbx_sync #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = async_in;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/qbx_dst.sv
`timescale 1ns/1ps
module qbx_dst
    import qbx_pkg::*;
#(
    parameter int         DATA_W = 64,
    parameter qbx_event_e EVENT  = QBX_EV_RISE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_sync,
    input  logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] word,
    output logic              valid
);
    typedef struct packed {
        logic              prev;
        logic [DATA_W-1:0] word;
        logic              valid;
    } dst_state_t;

    dst_state_t st_d, st_q;
    logic       load;

    always_comb begin
        if (EVENT == QBX_EV_RISE) begin
            load = upd_sync & ~st_q.prev;
        end else begin
            load = upd_sync ^ st_q.prev;
        end
        st_d       = st_q;
        st_d.prev  = upd_sync;
        st_d.valid = load;
        if (load) begin
            st_d.word = bus;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word  = st_q.word;
    assign valid = st_q.valid;
endmodule

// File: rtl/qual_bus_xfer.sv
`timescale 1ns/1ps
module qual_bus_xfer
    import qbx_pkg::*;
#(
    parameter int         DATA_W      = 64,
    parameter int         HOLD_CYC    = 8,
    parameter int         MIN_GAP     = 48,
    parameter int         SYNC_STAGES = 3,
    parameter qbx_event_e EVENT       = QBX_EV_RISE
) (
    input  logic              src_clk,
    input  logic              src_rst_n,
    input  logic              src_send,
    input  logic [DATA_W-1:0] src_word,
    output logic              src_busy,
    output logic              src_err,
    input  logic              dst_clk,
    input  logic              dst_rst_n,
    output logic [DATA_W-1:0] dst_word,
    output logic              dst_valid
);
    logic [DATA_W-1:0] launch_word;
    logic              upd_lvl;
    logic              upd_sync;

    qbx_src #(
        .DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC), .MIN_GAP(MIN_GAP), .EVENT(EVENT)
    ) u_src (
        .clk(src_clk), .rst_n(src_rst_n), .send(src_send), .word(src_word),
        .launch_word(launch_word), .upd_lvl(upd_lvl), .busy(src_busy), .err(src_err)
    );

    // Only the qualifier is synchronized; the word crosses as a held bus.
    qbx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(dst_clk), .rst_n(dst_rst_n), .async_in(upd_lvl), .sync_out(upd_sync)
    );

    qbx_dst #(.DATA_W(DATA_W), .EVENT(EVENT)) u_dst (
        .clk(dst_clk), .rst_n(dst_rst_n), .upd_sync(upd_sync), .bus(launch_word),
        .word(dst_word), .valid(dst_valid)
    );
endmodule

// File: rtl/qbx_chk.sv
`timescale 1ns/1ps
module qbx_chk #(
    parameter int DATA_W = 64
) (
    input logic              src_clk,
    input logic              src_rst_n,
    input logic              src_send,
    input logic              src_busy,
    input logic              src_err,
    input logic [DATA_W-1:0] launch_word,
    input logic              dst_clk,
    input logic              dst_rst_n,
    input logic [DATA_W-1:0] dst_word,
    input logic              dst_valid
);
    p_valid_single_r3: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_valid |=> !dst_valid);

    p_word_hold_r4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        !dst_valid |-> $stable(dst_word));

    p_busy_after_send_r5: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_send && !src_busy) |=> src_busy);

    p_refused_send_flags_r7: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (src_send && src_busy) |=> src_err);

    p_err_sticky_r7: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_err |=> src_err);

    p_launch_held_r10: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        src_busy |=> $stable(launch_word));
endmodule

bind qual_bus_xfer qbx_chk #(.DATA_W(DATA_W)) i_chk (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_send(src_send),
    .src_busy(src_busy), .src_err(src_err), .launch_word(launch_word),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_word(dst_word),
    .dst_valid(dst_valid)
);

// File: tb/test_qual_bus_xfer.sv
`timescale 1ns/1ps
module test_qual_bus_xfer;
    import qbx_pkg::*;
    localparam int W   = 64;
    localparam int GAP = 48;

    logic         src_clk = 1'b0, dst_clk = 1'b0;
    logic         src_rst_n = 1'b0, dst_rst_n = 1'b0;
    logic         send = 1'b0;
    logic [W-1:0] din = '0;
    logic         busy_e, err_e, dv_e, busy_t, err_t, dv_t;
    logic [W-1:0] dd_e, dd_t;

    always #2 src_clk = ~src_clk;   // 250 MHz
    always #3 dst_clk = ~dst_clk;

    qual_bus_xfer #(.DATA_W(W), .MIN_GAP(GAP), .EVENT(QBX_EV_RISE)) i_qual_bus_xfer (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_send(send), .src_word(din),
        .src_busy(busy_e), .src_err(err_e), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .dst_word(dd_e), .dst_valid(dv_e));

    qual_bus_xfer #(.DATA_W(W), .MIN_GAP(GAP), .EVENT(QBX_EV_TOGGLE)) i_qual_bus_xfer_tgl (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_send(send), .src_word(din),
        .src_busy(busy_t), .src_err(err_t), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
        .dst_word(dd_t), .dst_valid(dv_t));

    int  n_chk = 0, n_bad = 0;
    int  vc_e = 0, vc_t = 0;
    bit  done = 1'b0;

    always @(negedge dst_clk) begin
        if (dv_e) vc_e++;
        if (dv_t) vc_t++;
    end

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // R1: reset state of both domains
    task automatic t_reset();
        send = 1'b0;
        src_rst_n = 1'b0;
        dst_rst_n = 1'b0;
        repeat (4) @(negedge dst_clk);
        @(negedge src_clk);
        src_rst_n = 1'b1;
        dst_rst_n = 1'b1;
        @(negedge dst_clk);
        chk(dv_e == 1'b0 && dv_t == 1'b0, "R1 valid", W'({dv_e, dv_t}), '0);
        chk(dd_e == '0 && dd_t == '0, "R1 word", dd_e | dd_t, '0);
        @(negedge src_clk);
        chk(!busy_e && !busy_t, "R1 busy", W'({busy_e, busy_t}), '0);
        chk(!err_e && !err_t, "R1 err", W'({err_e, err_t}), '0);
    endtask

    // R2 R3 R5 R8 R9 R10: one accepted transfer, then input scrambled
    task automatic t_send(input logic [W-1:0] word);
        int ve0, vt0;
        while (busy_e) @(negedge src_clk);
        send = 1'b1;
        din  = word;
        @(negedge src_clk);
        send = 1'b0;
        din  = ~word;                       // R10: live input changes after launch
        ve0 = vc_e;
        vt0 = vc_t;
        fork
            begin
                int b = 0;
                while (busy_e && b < 200) begin
                    b++;
                    @(negedge src_clk);
                end
                chk(b == GAP, "R5 busy length", W'(b), W'(GAP));
            end
            begin
                int k = 0;
                while (!dv_e && k < 20) begin
                    @(negedge dst_clk);
                    k++;
                end
                chk(k >= 3 && k <= 7, "R8 latency", W'(k), W'(5));
                chk(dv_e, "R2 valid seen", W'(dv_e), W'(1));
                chk(dd_e == word, "R2/R10 word", dd_e, word);
                chk(dv_t && dd_t == word, "R9 toggle word", dd_t, word);
                @(negedge dst_clk);
                chk(!dv_e && !dv_t, "R3 single pulse", W'({dv_e, dv_t}), '0);
                chk(vc_e - ve0 == 1 && vc_t - vt0 == 1, "R3/R9 pulse count",
                    W'((vc_e - ve0) * 16 + (vc_t - vt0)), W'(17));
            end
        join
    endtask

    // R4: the output word holds with no new transfer
    task automatic t_hold(input logic [W-1:0] word);
        int ve0 = vc_e;
        repeat (40) @(negedge dst_clk);
        chk(vc_e == ve0, "R4 no spurious valid", W'(vc_e - ve0), '0);
        chk(dd_e == word && dd_t == word, "R4 word held", dd_e, word);
    endtask

    // R6 R7: a send during busy is refused and flagged
    task automatic t_refused(input logic [W-1:0] good, input logic [W-1:0] bad);
        int ve0, vt0;
        chk(!err_e && !err_t, "R7 err clear before", W'({err_e, err_t}), '0);
        while (busy_e) @(negedge src_clk);
        ve0 = vc_e;
        vt0 = vc_t;
        send = 1'b1;
        din  = good;
        @(negedge src_clk);
        send = 1'b0;
        repeat (5) @(negedge src_clk);
        send = 1'b1;
        din  = bad;
        @(negedge src_clk);
        send = 1'b0;
        chk(err_e && err_t, "R7 err raised", W'({err_e, err_t}), W'(3));
        repeat (60) @(negedge dst_clk);
        chk(vc_e - ve0 == 1 && vc_t - vt0 == 1, "R6 one delivery",
            W'((vc_e - ve0) * 16 + (vc_t - vt0)), W'(17));
        chk(dd_e == good && dd_t == good, "R6 word unchanged", dd_e, good);
        repeat (30) @(negedge src_clk);
        chk(err_e && err_t, "R7 err sticky", W'({err_e, err_t}), W'(3));
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_send(64'h0123_4567_89AB_CDEF);
        t_send('1);                          // minimum spacing, all ones
        t_send('0);                          // minimum spacing, all zeros
        t_send(64'hA5A5_5A5A_F00F_0FF0);
        t_hold(64'hA5A5_5A5A_F00F_0FF0);
        t_refused(64'h1111_2222_3333_4444, 64'hDEAD_BEEF_CAFE_F00D);
        t_send(64'h8000_0000_0000_0001);
        chk(err_e, "R7 err survives transfer", W'(err_e), W'(1));
        t_reset();
        t_send(64'h5555_AAAA_5555_AAAA);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule